// File: doc/BRIEF.md
# Real-Time Clock Update Engine

This block holds the time of day and the calendar as eight byte registers: seconds, minutes, hours, day of week, day of month, month, year and century. A sub-second divider counts strobes from a 32.768 kHz timebase and moves the calendar forward by one second when it wraps. Every carry, up to the century, resolves in that same clock. Values are kept either as packed BCD or as plain binary. Hours are kept either on a 0-23 scale or on a 1-12 scale with a PM flag.

System logic steers the engine through a three-bit divider-control field and a SET level that freezes the count. It loads the time through a byte write port. An update-in-progress status output warns a reader that the bank is about to change. A sticky update-ended flag, cleared by an acknowledge pulse, marks every completed advance.

Top module: `rtc_time_engine`

## Requirements
- R1: After reset, the bank reads century 0x20, year 0x00, month 0x01, day of month 0x01, day of week 0x01, hours 0x00, minutes 0x00 and seconds 0x00. `uip` and `uf` are both 0.
- R2: The engine runs only when `set_mode` is 0 and `div_ctl` is 3'b010 or below. While it runs, every TB_HZ-th `tb_tick` strobe advances the time by one second, and no earlier strobe does.
- R3: `uip` is 1 while the engine runs and the divider sits in its last UIP_TICKS counts of the second. It returns to 0 on the clock edge that advances the time.
- R4: While `set_mode` is 1, `uip` is 0 and the time registers hold their value under timebase strobes.
- R5: A `div_ctl` of 3'b11x holds the divider at zero with no advance. On release into a running setting, the divider restarts at TB_HZ/2, so the first advance comes TB_HZ/2 strobes after the release edge.
- R6: A `div_ctl` of 3'b011, 3'b100 or 3'b101 stops the count without clearing the divider. Counting resumes from the held position.
- R7: With `bin_mode` 0, every field is BCD, with tens in bits 7:4 and units in bits 3:0. With `bin_mode` 1, every field is plain binary.
- R8: With `hour24` 0, the hours field holds 1 to 12, with 12 standing for hour zero, and bit 7 set for PM. With `hour24` 1, it holds 0 to 23.
- R9: Carries ripple through seconds (0-59), minutes (0-59), hours, day of week (1-7), day of month, month (1-12), year (0-99) and century. Month lengths are 31/30/28, and February has 29 days when the year is divisible by 4.
- R10: `uf` is set on every advance and stays set until `uf_ack` clears it. An advance in the same cycle as `uf_ack` wins.
- R11: A write to addresses 0-7 (0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 7 century) shows on the outputs after the next clock edge, and writes to other addresses are ignored. A write while running leaves the divider alone. A write while `set_mode` is 1 clears the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tb_tick | input | 1 | One-cycle strobe per timebase period |
| div_ctl | input | 3 | Divider-control field |
| set_mode | input | 1 | Freeze updates while 1 |
| bin_mode | input | 1 | 1 = binary fields, 0 = BCD |
| hour24 | input | 1 | 1 = 24-hour, 0 = 12-hour with PM bit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | 8 | Register write data |
| uf_ack | input | 1 | Clears the update-ended flag |
| uip | output | 1 | Update in progress |
| uf | output | 1 | Update-ended flag |
| t_sec | output | 8 | Seconds |
| t_min | output | 8 | Minutes |
| t_hour | output | 8 | Hours |
| t_dow | output | 8 | Day of week |
| t_dom | output | 8 | Day of month |
| t_mon | output | 8 | Month |
| t_year | output | 8 | Year modulo 100 |
| t_cent | output | 8 | Century |

## Verification
A register write shows on the time outputs one edge later. An advance shows on the time outputs and on `uf` one edge after the strobe that wraps the divider. `uip` follows the divider with no added delay, and it falls to 0 combinationally when `set_mode` goes to 1. The bench drives inputs on the falling edge and samples on the falling edge after a counted number of rising edges. A run of TB_HZ-1 strobes must leave the bank untouched with `uip` high, and one more strobe must complete the advance. The half-second restart and the paused divider are checked the same way, one edge before and one edge after the predicted advance.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NREG = 8;

  // Field value from its stored byte.
  function automatic logic [7:0] fld_dec(input logic [7:0] b, input logic bin);
    logic [7:0] v;
    if (bin) v = b;
    else     v = 8'(b[7:4]) * 8'd10 + 8'(b[3:0]);
    return v;
  endfunction

  // Stored byte from a field value (0..99).
  function automatic logic [7:0] fld_enc(input logic [7:0] v, input logic bin);
    logic [7:0] tens, ones;
    tens = v / 8'd10;
    ones = v % 8'd10;
    if (bin) return v;
    return {tens[3:0], ones[3:0]};
  endfunction

  // Hour byte to 0..23.
  function automatic logic [7:0] hr_dec(input logic [7:0] b, input logic bin, input logic h24);
    logic [7:0] h;
    if (h24) begin
      h = fld_dec(b, bin);
    end else begin
      h = fld_dec({1'b0, b[6:0]}, bin);
      if (h == 8'd12) h = 8'd0;
      if (b[7]) h = h + 8'd12;
    end
    return h;
  endfunction

  // 0..23 to hour byte.
  function automatic logic [7:0] hr_enc(input logic [7:0] h, input logic bin, input logic h24);
    logic [7:0] h12, r;
    if (h24) return fld_enc(h, bin);
    h12 = h % 8'd12;
    if (h12 == 8'd0) h12 = 8'd12;
    r = fld_enc(h12, bin);
    r[7] = (h >= 8'd12);
    return r;
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mo, input logic [7:0] yr);
    case (mo)
      8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
      8'd2:                    return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      default:                 return 8'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int TB_HZ     = 32768,
  parameter int UIP_TICKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic [2:0] div_ctl_i,
  input  logic       set_i,
  input  logic       wr_i,
  output logic       run_o,
  output logic       sec_adv_o,
  output logic       uip_o
);
  localparam int CNT_W = $clog2(TB_HZ);
  localparam logic [CNT_W-1:0] LAST      = CNT_W'(TB_HZ - 1);
  localparam logic [CNT_W-1:0] HALF      = CNT_W'(TB_HZ / 2);
  localparam logic [CNT_W-1:0] UIP_START = CNT_W'(TB_HZ - UIP_TICKS);

  logic [CNT_W-1:0] cnt;
  logic             hold_q;
  logic             dreset;
  logic             release_ev;

  assign dreset     = div_ctl_i[2] & div_ctl_i[1];
  assign run_o      = !set_i && (div_ctl_i <= 3'b010);
  assign release_ev = hold_q && run_o;
  assign sec_adv_o  = run_o && !release_ev && tick_i && (cnt == LAST);
  assign uip_o      = run_o && (cnt >= UIP_START);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      hold_q <= 1'b0;
    end else begin
      hold_q <= dreset;
      if (dreset)                cnt <= '0;
      else if (release_ev)       cnt <= HALF;
      else if (set_i && wr_i)    cnt <= '0;
      else if (run_o && tick_i)  cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  // R3: an advance is always preceded by the warning window
  p_uip_before_adv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sec_adv_o |-> uip_o);
  // R3: the warning drops right after the advance
  p_uip_low_after_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sec_adv_o |=> !uip_o);
  // R5: no advance on the edge after the divider was held in reset
  p_no_adv_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dreset |=> !sec_adv_o);
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   adv_i,
  input  logic                   bin_i,
  input  logic                   h24_i,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [7:0]             wr_data_i,
  output logic                   wr_hit_o,
  output logic [NREG-1:0][7:0]   bank_o
);
  localparam int IDX_W = $clog2(NREG);
  localparam logic [NREG-1:0][7:0] RST_BANK =
    {8'h20, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  logic [NREG-1:0][7:0] bank, nxt;
  logic [7:0] s, mi, h, dw, dm, mo, yr, ce;
  logic [7:0] ns, nmi, nh, ndw, ndm, nmo, nyr, nce;

  assign wr_hit_o = wr_en_i && (wr_addr_i < ADDR_W'(NREG));
  assign bank_o   = bank;

  always_comb begin
    s  = fld_dec(bank[0], bin_i);
    mi = fld_dec(bank[1], bin_i);
    h  = hr_dec(bank[2], bin_i, h24_i);
    dw = fld_dec(bank[3], bin_i);
    dm = fld_dec(bank[4], bin_i);
    mo = fld_dec(bank[5], bin_i);
    yr = fld_dec(bank[6], bin_i);
    ce = fld_dec(bank[7], bin_i);
    ns = s + 8'd1; nmi = mi; nh = h; ndw = dw; ndm = dm; nmo = mo; nyr = yr; nce = ce;
    if (s >= 8'd59) begin
      ns  = 8'd0;
      nmi = mi + 8'd1;
      if (mi >= 8'd59) begin
        nmi = 8'd0;
        nh  = h + 8'd1;
        if (h >= 8'd23) begin
          nh  = 8'd0;
          ndw = (dw >= 8'd7) ? 8'd1 : dw + 8'd1;
          ndm = dm + 8'd1;
          if (dm >= month_len(mo, yr)) begin
            ndm = 8'd1;
            nmo = mo + 8'd1;
            if (mo >= 8'd12) begin
              nmo = 8'd1;
              nyr = yr + 8'd1;
              if (yr >= 8'd99) begin
                nyr = 8'd0;
                nce = (ce >= 8'd99) ? 8'd0 : ce + 8'd1;
              end
            end
          end
        end
      end
    end
    nxt[0] = fld_enc(ns, bin_i);
    nxt[1] = fld_enc(nmi, bin_i);
    nxt[2] = hr_enc(nh, bin_i, h24_i);
    nxt[3] = fld_enc(ndw, bin_i);
    nxt[4] = fld_enc(ndm, bin_i);
    nxt[5] = fld_enc(nmo, bin_i);
    nxt[6] = fld_enc(nyr, bin_i);
    nxt[7] = fld_enc(nce, bin_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bank <= RST_BANK;
    else if (wr_hit_o) bank[wr_addr_i[IDX_W-1:0]] <= wr_data_i;
    else if (adv_i)    bank <= nxt;
  end

  // R4/R6: without an advance or a write the bank is frozen
  p_bank_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !wr_hit_o) |=> $stable(bank));
  // R11: an accepted write lands on the next edge
  p_write_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit_o |=> bank[$past(wr_addr_i[IDX_W-1:0])] == $past(wr_data_i));
endmodule

// File: rtl/rtc_event_flag.sv
module rtc_event_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic ack_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (ack_i) flag_o <= 1'b0;
  end

  // R10: set on an advance, set wins over acknowledge
  p_flag_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  // R10: acknowledge alone clears
  p_flag_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/rtc_time_engine.sv
module rtc_time_engine
  import rtc_pkg::*;
#(
  parameter int TB_HZ     = 32768,
  parameter int UIP_TICKS = 8,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tb_tick,
  input  logic [2:0]        div_ctl,
  input  logic              set_mode,
  input  logic              bin_mode,
  input  logic              hour24,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              uf_ack,
  output logic              uip,
  output logic              uf,
  output logic [7:0]        t_sec,
  output logic [7:0]        t_min,
  output logic [7:0]        t_hour,
  output logic [7:0]        t_dow,
  output logic [7:0]        t_dom,
  output logic [7:0]        t_mon,
  output logic [7:0]        t_year,
  output logic [7:0]        t_cent
);
  logic                 run_w;
  logic                 sec_adv_w;
  logic                 wr_hit_w;
  logic [NREG-1:0][7:0] bank_w;

  rtc_divider #(.TB_HZ(TB_HZ), .UIP_TICKS(UIP_TICKS)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_i(tb_tick), .div_ctl_i(div_ctl),
    .set_i(set_mode), .wr_i(wr_hit_w), .run_o(run_w),
    .sec_adv_o(sec_adv_w), .uip_o(uip)
  );

  rtc_calendar #(.ADDR_W(ADDR_W)) u_cal (
    .clk(clk), .rst_n(rst_n), .adv_i(sec_adv_w), .bin_i(bin_mode),
    .h24_i(hour24), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .wr_hit_o(wr_hit_w), .bank_o(bank_w)
  );

  rtc_event_flag u_uf (
    .clk(clk), .rst_n(rst_n), .set_i(sec_adv_w), .ack_i(uf_ack), .flag_o(uf)
  );

  assign t_sec  = bank_w[0];
  assign t_min  = bank_w[1];
  assign t_hour = bank_w[2];
  assign t_dow  = bank_w[3];
  assign t_dom  = bank_w[4];
  assign t_mon  = bank_w[5];
  assign t_year = bank_w[6];
  assign t_cent = bank_w[7];

  // R2: advances only happen in a running setting
  p_adv_only_running_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_adv_w |-> (run_w && tb_tick));
  // R4: status is low under SET
  p_set_uip_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_mode |-> !uip);
endmodule

// File: tb/tb_rtc_time_engine.sv
module tb_rtc_time_engine;
  localparam int TB_HZ = 32;
  localparam int UIPT  = 8;

  logic clk = 0, rst_n = 0, tb_tick = 0;
  logic [2:0] div_ctl = 3'b010;
  logic set_mode = 0, bin_mode = 0, hour24 = 1;
  logic wr_en = 0, uf_ack = 0;
  logic [3:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic uip, uf;
  logic [7:0] t_sec, t_min, t_hour, t_dow, t_dom, t_mon, t_year, t_cent;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rtc_time_engine #(.TB_HZ(TB_HZ), .UIP_TICKS(UIPT), .ADDR_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .div_ctl(div_ctl),
    .set_mode(set_mode), .bin_mode(bin_mode), .hour24(hour24),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .uf_ack(uf_ack),
    .uip(uip), .uf(uf), .t_sec(t_sec), .t_min(t_min), .t_hour(t_hour),
    .t_dow(t_dow), .t_dom(t_dom), .t_mon(t_mon), .t_year(t_year), .t_cent(t_cent)
  );

  typedef struct packed {
    logic        bin;
    logic        h24;
    logic [63:0] vin;   // century..seconds, one byte each
    logic [63:0] vout;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b1, 64'h1999_1231_0723_5959, 64'h2000_0101_0100_0000},
    '{1'b0, 1'b1, 64'h2024_0615_0312_3456, 64'h2024_0615_0312_3457},
    '{1'b0, 1'b1, 64'h2024_0228_0223_5959, 64'h2024_0229_0300_0000},
    '{1'b0, 1'b1, 64'h2023_0228_0223_5959, 64'h2023_0301_0300_0000},
    '{1'b1, 1'b1, 64'h1432_041E_040A_3B3B, 64'h1432_041E_040B_0000},
    '{1'b0, 1'b0, 64'h2024_0310_0111_5959, 64'h2024_0310_0192_0000},
    '{1'b0, 1'b0, 64'h2024_0430_0791_5959, 64'h2024_0501_0112_0000},
    '{1'b1, 1'b0, 64'h1501_0105_020C_3B3B, 64'h1501_0105_0201_0000}
  };

  function automatic logic [63:0] bank();
    return {t_cent, t_year, t_mon, t_dom, t_dow, t_hour, t_min, t_sec};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    cyc(1);
    wr_en = 0;
  endtask

  task automatic load(input logic b, input logic h, input logic [63:0] v);
    tb_tick = 0; set_mode = 1; bin_mode = b; hour24 = h;
    for (int i = 0; i < 8; i++) wr(4'(i), v[i*8 +: 8]);
    set_mode = 0; uf_ack = 1;
    cyc(1);
    uf_ack = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] snap;
    string tag;
    cyc(3);
    // R1 reset state
    chk("R1 bank", bank(), 64'h2000_0101_0100_0000);
    chk("R1 uip/uf", {62'd0, uip, uf}, 64'd0);
    rst_n = 1;
    cyc(1);

    // Vector table: one advance each
    foreach (VECS[k]) begin
      tag = VECS[k].bin ? "R7" : (!VECS[k].h24 ? "R8" : "R9");
      load(VECS[k].bin, VECS[k].h24, VECS[k].vin);
      tb_tick = 1;
      cyc(TB_HZ - 1);
      chk("R2 no early advance", bank(), VECS[k].vin);
      chk("R3 uip in window", {63'd0, uip}, 64'd1);
      cyc(1);
      chk(tag, bank(), VECS[k].vout);
      chk("R10 uf set", {63'd0, uf}, 64'd1);
      chk("R3 uip cleared at advance", {63'd0, uip}, 64'd0);
    end

    // R3 window edge
    load(1'b0, 1'b1, 64'h2024_0101_0100_0000);
    tb_tick = 1;
    cyc(TB_HZ - UIPT - 1);
    chk("R3 uip before window", {63'd0, uip}, 64'd0);
    cyc(1);
    chk("R3 uip window start", {63'd0, uip}, 64'd1);

    // R4 SET freezes and drops uip
    set_mode = 1;
    #1;
    chk("R4 uip low under SET", {63'd0, uip}, 64'd0);
    snap = bank();
    cyc(3 * TB_HZ);
    chk("R4 bank frozen", bank(), snap);
    set_mode = 0;

    // R5 divider reset then half-second restart
    div_ctl = 3'b110;
    cyc(2 * TB_HZ);
    chk("R5 held bank", bank(), snap);
    chk("R5 held uip", {63'd0, uip}, 64'd0);
    div_ctl = 3'b010;
    cyc(TB_HZ / 2);
    chk("R5 no advance before half second", {56'd0, t_sec}, 64'h00);
    cyc(1);
    chk("R5 advance at half second", {56'd0, t_sec}, 64'h01);

    // R6 stop keeps divider position
    cyc(10);
    div_ctl = 3'b011;
    cyc(2 * TB_HZ);
    chk("R6 stopped", {56'd0, t_sec}, 64'h01);
    div_ctl = 3'b010;
    cyc(TB_HZ - 11);
    chk("R6 resumed not yet", {56'd0, t_sec}, 64'h01);
    cyc(1);
    chk("R6 resumed advance", {56'd0, t_sec}, 64'h02);

    // R11 write while running keeps divider
    cyc(10);
    wr(4'd0, 8'h45);
    chk("R11 write lands", {56'd0, t_sec}, 64'h45);
    cyc(TB_HZ - 12);
    chk("R11 no early advance", {56'd0, t_sec}, 64'h45);
    cyc(1);
    chk("R11 divider kept", {56'd0, t_sec}, 64'h46);

    // R11 write to unmapped address
    tb_tick = 0;
    snap = bank();
    wr(4'd9, 8'hFF);
    wr(4'd15, 8'hAA);
    chk("R11 unmapped ignored", bank(), snap);

    // R10 acknowledge clears
    uf_ack = 1;
    cyc(1);
    uf_ack = 0;
    chk("R10 ack clears", {63'd0, uf}, 64'd0);

    // R11 write under SET clears divider
    tb_tick = 1;
    cyc(20);
    set_mode = 1;
    wr(4'd0, 8'h10);
    set_mode = 0;
    cyc(TB_HZ - 1);
    chk("R11 SET write restarts divider", {56'd0, t_sec}, 64'h10);
    cyc(1);
    chk("R11 full second after SET write", {56'd0, t_sec}, 64'h11);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule